// File: doc/BRIEF.md
# Floating-Point Multiple Transfer Expander

This block sits behind an instruction decoder. It turns one floating-point load or store of several registers into a sequence of simple micro-ops. The decoder offers a 32-bit instruction word on a valid/ready input. The expander accepts it when idle and then emits the micro-ops one at a time on a valid/ready output. The final micro-op of each instruction is marked with a last flag.

Each transferred register becomes a group of three micro-ops. The first computes the group address. The second moves the low data word at the group address. The third moves the high data word four bytes above it. Successive groups move twelve bytes up or down in memory, depending on the direction bit. When the instruction asks for base writeback, one extra micro-op follows the groups. It carries a freshly built add or subtract word that moves the base register by the scaled displacement.

A mode input selects the multi-register form, where the count comes from two split instruction bits. It can also select the single-register form, where exactly one register is moved.

Top module: `fpx_expander`

## Requirements
- R1: In multi-register form (`in_single`=0) the register count is the two-bit code {instr[22], instr[15]}, with code 0 meaning four registers, and the block emits that many three-micro-op groups.
- R2: In single-register form (`in_single`=1) exactly one group is emitted whatever instr[22] and instr[15] hold.
- R3: The displacement is instr[7:0] multiplied by four. The first group address is the displacement when the pre-index bit instr[24] is 1, and zero when it is 0.
- R4: Group i (index output i) emits kinds 0 (address), 1 (low word), 2 (high word) in that order. Kinds 0 and 1 carry the group address as offset, and kind 2 carries the group address plus 4.
- R5: Each group address is the previous one plus 12 when the up bit instr[23] is 1, and minus 12 when it is 0, in 32-bit two's complement.
- R6: When instr[21] is 1, one extra micro-op follows the last group. Its kind is 3 (add) if instr[23] is 1 and 4 (subtract) otherwise, and it has offset 0 and index 0. Its word is instr[31:28] in bits 31:28, OR 0x02400000, the base number instr[19:16] in both bits 19:16 and 15:12, OR the displacement.
- R7: Exactly 3×count + instr[21] micro-ops are emitted, and `uop_last` is 1 on the final one only.
- R8: While `uop_valid` is 1 and `uop_ready` is 0, every output field holds its value into the next cycle.
- R9: After reset, `in_ready`=1 and `uop_valid`=0. An offer made while an expansion is in progress is ignored, and `in_ready` returns to 1 in the cycle after the final micro-op is taken.
- R10: Every address and data micro-op (kinds 0 to 2) carries the accepted instruction word unchanged in `uop_word`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Expander idle, offer taken on this edge |
| in_instr | input | 32 | Instruction word |
| in_single | input | 1 | 1 selects the single-register form |
| uop_valid | output | 1 | Micro-op present |
| uop_ready | input | 1 | Consumer takes the micro-op |
| uop_kind | output | 3 | 0 address, 1 low word, 2 high word, 3 writeback add, 4 writeback subtract |
| uop_index | output | 2 | Register group index within the transfer |
| uop_offset | output | 32 | Byte offset from the base register |
| uop_word | output | 32 | Instruction word or built writeback word |
| uop_last | output | 1 | Final micro-op of the instruction |

## Verification
The assertions assume that the consumer treats a micro-op as taken only on a cycle with both valid and ready high. They also assume the instruction word is sampled only on an accepting edge. The ordering and step properties then rely on `uop_word` bit 23 reflecting the latched instruction across a group boundary. The stimulus sweeps both forms, all four count codes, every pre/up/writeback combination and four displacements, including 0 and 0xFF. It withholds ready on a periodic pattern so that stalls land on every micro-op kind. On alternate runs it keeps offering a different instruction throughout the expansion, and it lowers that offer on the cycle the final micro-op is taken so that no unintended acceptance follows.

// File: rtl/fpx_pkg.sv
package fpx_pkg;

  localparam int INSTR_W    = 32;
  localparam int POS_PRE    = 24;
  localparam int POS_UP     = 23;
  localparam int POS_CNT_HI = 22;
  localparam int POS_WB     = 21;
  localparam int POS_CNT_LO = 15;
  localparam logic [INSTR_W-1:0] WB_OPC = 32'h0240_0000;

  typedef enum logic [2:0] {
    UOP_ADDR   = 3'd0,
    UOP_DLO    = 3'd1,
    UOP_DHI    = 3'd2,
    UOP_WB_ADD = 3'd3,
    UOP_WB_SUB = 3'd4
  } uop_kind_e;

  // number of registers moved; code 0 stands for four
  function automatic logic [2:0] fpx_reg_count(input logic [INSTR_W-1:0] instr,
                                               input logic single);
    logic [1:0] code;
    code = {instr[POS_CNT_HI], instr[POS_CNT_LO]};
    if (single)        return 3'd1;
    if (code == 2'd0)  return 3'd4;
    return {1'b0, code};
  endfunction

  // eight-bit immediate scaled to bytes
  function automatic logic [INSTR_W-1:0] fpx_disp(input logic [7:0] imm);
    return {{(INSTR_W-10){1'b0}}, imm, 2'b00};
  endfunction

  // base-adjust word: condition kept, opcode ORed, base as source and target
  function automatic logic [INSTR_W-1:0] fpx_wb_word(input logic [INSTR_W-1:0] instr);
    logic [INSTR_W-1:0] w;
    logic [3:0]         rn;
    rn = instr[19:16];
    w  = instr & 32'hF000_0000;
    w  = w | WB_OPC;
    w  = w | ({28'd0, rn} << 16) | ({28'd0, rn} << 12);
    w  = w | fpx_disp(instr[7:0]);
    return w;
  endfunction

endpackage

// File: rtl/fpx_decode.sv
module fpx_decode
  import fpx_pkg::*;
#(
  parameter int OFF_W = 32,
  parameter int CNT_W = 3,
  parameter int STEP  = 12
) (
  input  logic [INSTR_W-1:0] instr,
  input  logic               single,
  output logic [CNT_W-1:0]   cnt,
  output logic [OFF_W-1:0]   start_off,
  output logic [OFF_W-1:0]   step_off,
  output logic               wb_en,
  output logic               wb_sub,
  output logic [INSTR_W-1:0] wb_word
);

  logic [INSTR_W-1:0] disp;

  always_comb begin
    disp      = fpx_disp(instr[7:0]);
    cnt       = CNT_W'(fpx_reg_count(instr, single));
    start_off = instr[POS_PRE] ? OFF_W'(disp) : '0;
    step_off  = instr[POS_UP] ? OFF_W'(STEP) : (OFF_W'(0) - OFF_W'(STEP));
    wb_en     = instr[POS_WB];
    wb_sub    = !instr[POS_UP];
    wb_word   = fpx_wb_word(instr);
  end

endmodule

// File: rtl/fpx_sequencer.sv
module fpx_sequencer
  import fpx_pkg::*;
#(
  parameter int OFF_W = 32,
  parameter int CNT_W = 3,
  parameter int IDX_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [INSTR_W-1:0] in_instr,
  input  logic [CNT_W-1:0]   dec_cnt,
  input  logic [OFF_W-1:0]   dec_start,
  input  logic [OFF_W-1:0]   dec_step,
  input  logic               dec_wb,
  input  logic               dec_wb_sub,
  input  logic [INSTR_W-1:0] dec_wb_word,
  input  logic               out_ready,
  output logic               busy,
  output logic [IDX_W-1:0]   grp,
  output logic [1:0]         phase,
  output logic [OFF_W-1:0]   gaddr,
  output logic               wb_sub,
  output logic [INSTR_W-1:0] instr_q,
  output logic [INSTR_W-1:0] wb_word_q,
  output logic               last,
  output logic               ev_accept,
  output logic               ev_fire
);

  localparam logic [1:0] PH_ADDR = 2'd0;
  localparam logic [1:0] PH_HI   = 2'd2;
  localparam logic [1:0] PH_WB   = 2'd3;

  logic [CNT_W-1:0] cnt_q;
  logic [OFF_W-1:0] step_q;
  logic             wb_q;
  logic             last_grp;

  assign in_ready  = !busy;
  assign ev_accept = in_valid && !busy;
  assign ev_fire   = busy && out_ready;
  assign last_grp  = (CNT_W'(grp) + CNT_W'(1)) == cnt_q;
  assign last      = busy && ((phase == PH_WB) || (phase == PH_HI && last_grp && !wb_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      grp       <= '0;
      phase     <= PH_ADDR;
      gaddr     <= '0;
      cnt_q     <= '0;
      step_q    <= '0;
      wb_q      <= 1'b0;
      wb_sub    <= 1'b0;
      instr_q   <= '0;
      wb_word_q <= '0;
    end else if (ev_accept) begin
      busy      <= 1'b1;
      grp       <= '0;
      phase     <= PH_ADDR;
      gaddr     <= dec_start;
      cnt_q     <= dec_cnt;
      step_q    <= dec_step;
      wb_q      <= dec_wb;
      wb_sub    <= dec_wb_sub;
      instr_q   <= in_instr;
      wb_word_q <= dec_wb_word;
    end else if (ev_fire) begin
      if (last) begin
        busy  <= 1'b0;
        phase <= PH_ADDR;
        grp   <= '0;
      end else if (phase == PH_HI) begin
        if (last_grp) begin
          phase <= PH_WB;
        end else begin
          phase <= PH_ADDR;
          grp   <= grp + IDX_W'(1);
          gaddr <= gaddr + step_q;
        end
      end else begin
        phase <= phase + 2'd1;
      end
    end
  end

  // R1: the group index never reaches the latched count
  a_r1_index_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (CNT_W'(grp) < cnt_q));

  // R7: the writeback slot only exists when writeback was requested
  a_r7_wb_slot_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && phase == PH_WB) |-> wb_q);

endmodule

// File: rtl/fpx_uop_format.sv
module fpx_uop_format
  import fpx_pkg::*;
#(
  parameter int OFF_W  = 32,
  parameter int IDX_W  = 2,
  parameter int HI_OFF = 4
) (
  input  logic               busy,
  input  logic [1:0]         phase,
  input  logic [IDX_W-1:0]   grp,
  input  logic [OFF_W-1:0]   gaddr,
  input  logic               wb_sub,
  input  logic [INSTR_W-1:0] instr_q,
  input  logic [INSTR_W-1:0] wb_word_q,
  output logic               valid,
  output uop_kind_e          kind,
  output logic [IDX_W-1:0]   index,
  output logic [OFF_W-1:0]   offset,
  output logic [INSTR_W-1:0] word
);

  always_comb begin
    valid  = busy;
    index  = grp;
    offset = gaddr;
    word   = instr_q;
    unique case (phase)
      2'd0: kind = UOP_ADDR;
      2'd1: kind = UOP_DLO;
      2'd2: begin
        kind   = UOP_DHI;
        offset = gaddr + OFF_W'(HI_OFF);
      end
      default: begin
        kind   = wb_sub ? UOP_WB_SUB : UOP_WB_ADD;
        index  = '0;
        offset = '0;
        word   = wb_word_q;
      end
    endcase
  end

endmodule

// File: rtl/fpx_expander.sv
module fpx_expander
  import fpx_pkg::*;
#(
  parameter int OFF_W    = 32,
  parameter int MAX_REGS = 4,
  parameter int STEP     = 12,
  parameter int HI_OFF   = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_instr,
  input  logic        in_single,
  output logic        uop_valid,
  input  logic        uop_ready,
  output logic [2:0]  uop_kind,
  output logic [1:0]  uop_index,
  output logic [31:0] uop_offset,
  output logic [31:0] uop_word,
  output logic        uop_last
);

  localparam int CNT_W = $clog2(MAX_REGS + 1);
  localparam int IDX_W = $clog2(MAX_REGS);

  logic [CNT_W-1:0]   dec_cnt;
  logic [OFF_W-1:0]   dec_start, dec_step;
  logic               dec_wb, dec_wb_sub;
  logic [INSTR_W-1:0] dec_wb_word;

  logic               busy, wb_sub, ev_accept, ev_fire;
  logic [IDX_W-1:0]   grp;
  logic [1:0]         phase;
  logic [OFF_W-1:0]   gaddr;
  logic [INSTR_W-1:0] instr_q, wb_word_q;
  uop_kind_e          kind;
  logic [IDX_W-1:0]   idx;
  logic [OFF_W-1:0]   off;

  fpx_decode #(.OFF_W(OFF_W), .CNT_W(CNT_W), .STEP(STEP)) u_dec (
    .instr(in_instr), .single(in_single), .cnt(dec_cnt), .start_off(dec_start),
    .step_off(dec_step), .wb_en(dec_wb), .wb_sub(dec_wb_sub), .wb_word(dec_wb_word)
  );

  fpx_sequencer #(.OFF_W(OFF_W), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_instr(in_instr), .dec_cnt(dec_cnt), .dec_start(dec_start),
    .dec_step(dec_step), .dec_wb(dec_wb), .dec_wb_sub(dec_wb_sub),
    .dec_wb_word(dec_wb_word), .out_ready(uop_ready), .busy(busy), .grp(grp),
    .phase(phase), .gaddr(gaddr), .wb_sub(wb_sub), .instr_q(instr_q),
    .wb_word_q(wb_word_q), .last(uop_last), .ev_accept(ev_accept), .ev_fire(ev_fire)
  );

  fpx_uop_format #(.OFF_W(OFF_W), .IDX_W(IDX_W), .HI_OFF(HI_OFF)) u_fmt (
    .busy(busy), .phase(phase), .grp(grp), .gaddr(gaddr), .wb_sub(wb_sub),
    .instr_q(instr_q), .wb_word_q(wb_word_q), .valid(uop_valid), .kind(kind),
    .index(idx), .offset(off), .word(uop_word)
  );

  assign uop_kind   = kind;
  assign uop_index  = 2'(idx);
  assign uop_offset = 32'(off);

  // R8: a stalled micro-op holds every field
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_valid && !uop_ready) |=> (uop_valid && $stable(uop_kind) && $stable(uop_index)
      && $stable(uop_offset) && $stable(uop_word) && $stable(uop_last)));

  // R9: taking the final micro-op frees the input side
  a_r9_reopen: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_fire && uop_last) |=> in_ready);

  // R7: the stream does not break before the last flag
  a_r7_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_fire && !uop_last) |=> uop_valid);

  // R6: a writeback micro-op always closes the stream
  a_r6_wb_is_last: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_valid && (uop_kind == UOP_WB_ADD || uop_kind == UOP_WB_SUB)) |-> uop_last);

  // R4: address is followed by the low word, low by high
  a_r4_addr_then_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_fire && uop_kind == UOP_ADDR) |=> (uop_valid && uop_kind == UOP_DLO
      && uop_offset == $past(uop_offset)));
  a_r4_lo_then_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_fire && uop_kind == UOP_DLO) |=> (uop_valid && uop_kind == UOP_DHI
      && uop_offset == $past(uop_offset) + 32'd4));

  // R5: next group address moves by twelve in the instruction's direction
  a_r5_group_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_fire && uop_kind == UOP_DHI && !uop_last && uop_word[POS_WB] == 1'b0)
      |=> (uop_kind == UOP_ADDR && uop_offset == $past(uop_offset) - 32'd4
        + (uop_word[POS_UP] ? 32'd12 : 32'hFFFF_FFF4)));

  // R9: no acceptance while a stream is pending
  a_r9_single_accept: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> (uop_valid && uop_kind == UOP_ADDR && uop_index == 2'd0));

endmodule

// File: tb/fpx_expander_tb.sv
module fpx_expander_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_instr = '0;
  logic        in_single = 1'b0;
  logic        uop_valid;
  logic        uop_ready = 1'b0;
  logic [2:0]  uop_kind;
  logic [1:0]  uop_index;
  logic [31:0] uop_offset;
  logic [31:0] uop_word;
  logic        uop_last;

  int checks = 0;
  int errors = 0;
  int stall_ctr = 0;
  int cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fpx_expander dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_instr(in_instr), .in_single(in_single), .uop_valid(uop_valid),
    .uop_ready(uop_ready), .uop_kind(uop_kind), .uop_index(uop_index),
    .uop_offset(uop_offset), .uop_word(uop_word), .uop_last(uop_last)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  task automatic run_one(input logic [31:0] ins, input logic single, input bit junk);
    int n, total, k, guard, g, p, start, gad, disp;
    bit pre, up, wb, stall, prev_stall;
    logic [31:0] exp_word, exp_off;
    logic [2:0]  exp_kind;
    logic [1:0]  exp_idx;
    string tag;
    pre  = ins[24];
    up   = ins[23];
    wb   = ins[21];
    disp = int'(ins[7:0]) * 4;
    if (single) n = 1;
    else n = (int'({ins[22], ins[15]}) == 0) ? 4 : int'({ins[22], ins[15]});
    total = 3 * n + (wb ? 1 : 0);
    start = pre ? disp : 0;

    @(negedge clk);
    check("R9 idle before offer", {63'd0, in_ready}, 64'd1);
    in_valid  = 1'b1;
    in_instr  = ins;
    in_single = single;
    @(negedge clk);
    if (junk) begin
      in_instr  = ~ins;
      in_single = ~single;
    end else begin
      in_valid = 1'b0;
    end

    k = 0;
    guard = 0;
    prev_stall = 0;
    while (k < total && guard < 200) begin
      if (wb && k == 3 * n) begin
        exp_kind = up ? 3'd3 : 3'd4;
        exp_idx  = 2'd0;
        exp_off  = 32'd0;
        exp_word = {ins[31:28], 8'h24, ins[19:16], ins[19:16], 12'd0} + 32'(disp);
        tag = "R6";
      end else begin
        g = k / 3;
        p = k % 3;
        gad = up ? start + 12 * g : start - 12 * g;
        exp_kind = 3'(p);
        exp_idx  = 2'(g);
        exp_off  = 32'(gad + ((p == 2) ? 4 : 0));
        exp_word = ins;
        if (p == 2)      tag = "R4";
        else if (p == 1) tag = single ? "R2" : "R1";
        else if (g == 0) tag = "R3";
        else             tag = "R5";
      end
      if (prev_stall) tag = {tag, " R8"};
      check(tag, {uop_valid, uop_kind, uop_index, uop_offset},
                 {1'b1, exp_kind, exp_idx, exp_off});
      check((exp_kind > 3'd2) ? "R6 word" : "R10 word", {32'd0, uop_word}, {32'd0, exp_word});
      check("R7 last", {63'd0, uop_last}, {63'd0, (k == total - 1)});
      stall = (stall_ctr % 5 == 3);
      stall_ctr++;
      uop_ready = !stall;
      if (!stall && k == total - 1) in_valid = 1'b0;
      @(negedge clk);
      if (!stall) k++;
      prev_stall = stall;
      guard++;
    end
    uop_ready = 1'b0;
    in_valid  = 1'b0;
    check("R9 free after final", {62'd0, in_ready, uop_valid}, 64'd2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset state", {61'd0, in_ready, uop_valid, uop_last}, 64'd4);
    rst_n = 1'b1;
    check("R9 after release", {62'd0, in_ready, uop_valid}, 64'd2);
    for (int s = 0; s < 2; s++) begin
      for (int c = 0; c < 4; c++) begin
        for (int m = 0; m < 8; m++) begin
          for (int d = 0; d < 4; d++) begin
            logic [31:0] ins;
            logic [7:0]  imm;
            imm = (d == 0) ? 8'h00 : (d == 1) ? 8'h01 : (d == 2) ? 8'hFF : 8'h5A;
            ins = 32'h0C00_0200;
            ins[31:28] = 4'(m + d + c);
            ins[24] = m[2];
            ins[23] = m[1];
            ins[21] = m[0];
            ins[22] = c[1];
            ins[15] = c[0];
            ins[20] = d[0];
            ins[19:16] = 4'(3 * c + d + s);
            ins[14:12] = 3'(m);
            ins[7:0] = imm;
            run_one(ins, s[0], (d % 2) == 1);
          end
        end
      end
    end
    finish_run();
  end

endmodule